// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This core runs a compact 32-bit instruction subset with one instruction completed per clock. Each cycle fetches a word from an internal instruction array at the program counter. It decodes that word in two levels. The first level maps the opcode to a set of control strobes plus a 2-bit ALU class. The second level combines that class with the funct field to pick a 3-bit ALU operation. The core then reads two registers, computes, optionally touches an internal data array, and updates the register file and the program counter on the next rising edge.

Both memories are word arrays, indexed by address bits [N:2], and are filled by the surrounding testbench before reset is released. The only ports are the clock, a synchronous reset, and a debug view of the current program counter and of the register write that the current instruction will commit at the next edge. This lets a bench follow execution one instruction at a time.

Top module: `sc_cpu_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0, and `dbgRegWe` stays low during reset.
- R2: An instruction that neither jumps nor takes a branch leaves PC+4 as the next PC.
- R3: Load (opcode 0x23) writes data word [(rs + sign-extended imm[15:0]) >> 2] into register rt (bits 20-16), with rs in bits 25-21.
- R4: Store (opcode 0x2B) writes register rt into data word [(rs + sign-extended imm) >> 2], and reports no register write. A later load of that address returns the stored value.
- R5: R-type (opcode 0x00) writes rd (bits 15-11) with rs op rt. The operation comes from funct (bits 5-0): 0x20 add, 0x22 subtract (two's complement), 0x24 AND, 0x25 OR.
- R6: R-type funct 0x2A writes 1 to rd when rs is less than rt as signed values, and 0 otherwise.
- R7: Register 0 always reads as zero. A write aimed at it changes nothing and reports no write.
- R8: Branch-equal (opcode 0x04) compares rs and rt. When they are equal, the next PC is PC+4 + (sign-extended imm << 2), and backward offsets work. Otherwise the next PC is PC+4. The instruction writes no register.
- R9: Jump (opcode 0x02) sets the next PC to {(PC+4)[31:28], instr[25:0], 2'b00} and writes no register.
- R10: The ALU operation codes are 000 AND, 001 OR, 010 add, 110 subtract and 111 set-less-than. Loads and stores use add, branch-equal uses subtract, and its zero flag decides the branch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dbgPc | output | 32 | Address of the instruction executing this cycle |
| dbgRegWe | output | 1 | High when this instruction commits a register write at the next edge |
| dbgRegAddr | output | 5 | Destination register of that write |
| dbgRegData | output | 32 | Value being written |

## Verification
The program starts by loading three constants: a positive pair and a negative value. It then applies every R-type operation to them. Running set-less-than in both operand orders, with a negative operand, separates a signed compare from an unsigned one. A write aimed at register 0, followed by an add that reads it, shows whether register 0 is really protected. A store followed by a load from the same word shows the data path through memory. A branch that is not taken, a forward taken branch over two poisoned instructions, a jump whose field sets bit 27 of the target, and a backward branch onto itself each produce a PC trace that differs between correct and wrong target arithmetic. A mid-run reset followed by re-execution checks the restart.

// File: rtl/sc_cpu_pkg.sv
package sc_cpu_pkg;

  localparam int XLEN = 32;
  localparam int REG_COUNT = 32;
  localparam int REG_AW = $clog2(REG_COUNT);

  typedef enum logic [5:0] {
    OP_RTYPE = 6'h00,
    OP_JUMP  = 6'h02,
    OP_BEQ   = 6'h04,
    OP_LOAD  = 6'h23,
    OP_STORE = 6'h2B
  } opcode_e;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10
  } alu_class_e;

  typedef struct packed {
    logic    regDst;
    logic    aluSrc;
    logic    memToReg;
    logic    regWrite;
    logic    memRead;
    logic    memWrite;
    logic    branch;
    logic    jump;
    alu_op_e aluCtrl;
  } ctrl_t;

endpackage

// File: rtl/sc_alu.sv
module sc_alu
  import sc_cpu_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  alu_op_e      op,
  output logic [W-1:0] res,
  output logic         zero
);

  always_comb begin
    case (op)
      ALU_AND: res = opA & opB;
      ALU_OR:  res = opA | opB;
      ALU_ADD: res = opA + opB;
      ALU_SUB: res = opA - opB;
      ALU_SLT: res = {{(W-1){1'b0}}, ($signed(opA) < $signed(opB))};
      default: res = opA + opB;
    endcase
  end

  assign zero = (res == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W = 32,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wAddr,
  input  logic [W-1:0]  wData,
  input  logic [AW-1:0] rAddrA,
  input  logic [AW-1:0] rAddrB,
  output logic [W-1:0]  rDataA,
  output logic [W-1:0]  rDataB
);

  logic [W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (we && (wAddr != '0)) begin
      regs[wAddr] <= wData;
    end
  end

  assign rDataA = regs[rAddrA];
  assign rDataB = regs[rAddrB];

  // R7: entry zero keeps its reset value whatever is written
  a_r7_zero_reg_held: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> regs[0] == '0);

endmodule

// File: rtl/sc_control.sv
module sc_control
  import sc_cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);

  alu_class_e aluClass;

  // first level: opcode to strobes and ALU class
  always_comb begin
    ctl = '0;
    ctl.aluCtrl = ALU_ADD;
    aluClass = CLS_ADD;
    case (opcode_e'(opcode))
      OP_RTYPE: begin
        ctl.regDst   = 1'b1;
        ctl.regWrite = 1'b1;
        aluClass     = CLS_FUNCT;
      end
      OP_LOAD: begin
        ctl.aluSrc   = 1'b1;
        ctl.memToReg = 1'b1;
        ctl.regWrite = 1'b1;
        ctl.memRead  = 1'b1;
        aluClass     = CLS_ADD;
      end
      OP_STORE: begin
        ctl.aluSrc   = 1'b1;
        ctl.memWrite = 1'b1;
        aluClass     = CLS_ADD;
      end
      OP_BEQ: begin
        ctl.branch = 1'b1;
        aluClass   = CLS_SUB;
      end
      OP_JUMP: begin
        ctl.jump = 1'b1;
      end
      default: ;
    endcase

    // second level: class plus funct to ALU code
    case (aluClass)
      CLS_SUB:   ctl.aluCtrl = ALU_SUB;
      CLS_FUNCT: begin
        case (funct)
          FN_ADD:  ctl.aluCtrl = ALU_ADD;
          FN_SUB:  ctl.aluCtrl = ALU_SUB;
          FN_AND:  ctl.aluCtrl = ALU_AND;
          FN_OR:   ctl.aluCtrl = ALU_OR;
          FN_SLT:  ctl.aluCtrl = ALU_SLT;
          default: ctl.aluCtrl = ALU_ADD;
        endcase
      end
      default:   ctl.aluCtrl = ALU_ADD;
    endcase
  end

  // R8: a branch never writes registers or memory
  a_r8_branch_no_write: assert property (@(posedge clk) disable iff (rst)
    ctl.branch |-> (!ctl.regWrite && !ctl.memWrite));

  // R10: loads and stores address with an add
  a_r10_mem_uses_add: assert property (@(posedge clk) disable iff (rst)
    (ctl.memRead || ctl.memWrite) |-> ctl.aluCtrl == ALU_ADD);

endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import sc_cpu_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctl,
  output logic [5:0]        opcode,
  output logic [5:0]        funct,
  output logic [XLEN-1:0]   dbgPc,
  output logic              dbgRegWe,
  output logic [REG_AW-1:0] dbgRegAddr,
  output logic [XLEN-1:0]   dbgRegData
);

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  initial begin
    for (int i = 0; i < IMEM_WORDS; i++) imem[i] = '0;
  end

  logic [XLEN-1:0]   pcQ, pcNext, pcPlus4, branchTgt, jumpTgt;
  logic [XLEN-1:0]   instr, immExt;
  logic [XLEN-1:0]   rdA, rdB, aluB, aluY, loadData, wbData;
  logic [REG_AW-1:0] wrAddr;
  logic              aluZero, regWe, takeBranch;
  logic [DAW-1:0]    dataIdx;

  assign instr     = imem[pcQ[IAW+1:2]];
  assign opcode    = instr[31:26];
  assign funct     = instr[5:0];
  assign pcPlus4   = pcQ + 32'd4;
  assign immExt    = {{16{instr[15]}}, instr[15:0]};
  assign branchTgt = pcPlus4 + (immExt << 2);
  assign jumpTgt   = {pcPlus4[31:28], instr[25:0], 2'b00};
  assign wrAddr    = ctl.regDst ? instr[15:11] : instr[20:16];

  sc_regfile #(.W(XLEN), .DEPTH(REG_COUNT)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (regWe),
    .wAddr (wrAddr),
    .wData (wbData),
    .rAddrA(instr[25:21]),
    .rAddrB(instr[20:16]),
    .rDataA(rdA),
    .rDataB(rdB)
  );

  assign aluB = ctl.aluSrc ? immExt : rdB;

  sc_alu #(.W(XLEN)) u_alu (
    .opA (rdA),
    .opB (aluB),
    .op  (ctl.aluCtrl),
    .res (aluY),
    .zero(aluZero)
  );

  assign dataIdx  = aluY[DAW+1:2];
  assign loadData = ctl.memRead ? dmem[dataIdx] : '0;
  assign wbData   = ctl.memToReg ? loadData : aluY;
  assign regWe    = ctl.regWrite && !rst;

  always_ff @(posedge clk) begin
    if (ctl.memWrite && !rst) dmem[dataIdx] <= rdB;
  end

  assign takeBranch = ctl.branch && aluZero;

  always_comb begin
    if (ctl.jump)        pcNext = jumpTgt;
    else if (takeBranch) pcNext = branchTgt;
    else                 pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pcQ <= '0;
    else     pcQ <= pcNext;
  end

  assign dbgPc      = pcQ;
  assign dbgRegWe   = regWe && (wrAddr != '0);
  assign dbgRegAddr = wrAddr;
  assign dbgRegData = wbData;

  // R2: sequential flow advances by one word
  a_r2_seq_pc: assert property (@(posedge clk) disable iff (rst)
    (!ctl.jump && !takeBranch) |=> pcQ == $past(pcQ) + 32'd4);

  // R8: a taken branch lands on the word-scaled offset from PC+4
  a_r8_branch_target: assert property (@(posedge clk) disable iff (rst)
    takeBranch |=> pcQ == $past(pcQ) + 32'd4 + ($past(immExt) << 2));

  // R9: a jump keeps the top nibble of PC+4 and is word aligned
  a_r9_jump_region: assert property (@(posedge clk) disable iff (rst)
    ctl.jump |=> (pcQ[31:28] == $past(pcPlus4[31:28])) && (pcQ[1:0] == 2'b00));

  // R10: a subtract reports zero exactly when the operands are equal
  a_r10_sub_zero: assert property (@(posedge clk) disable iff (rst)
    (ctl.aluCtrl == ALU_SUB) |-> (aluZero == (rdA == aluB)));

endmodule

// File: rtl/sc_cpu_core.sv
module sc_cpu_core
  import sc_cpu_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] dbgPc,
  output logic        dbgRegWe,
  output logic [4:0]  dbgRegAddr,
  output logic [31:0] dbgRegData
);

  ctrl_t      ctl;
  logic [5:0] opcode, funct;

  sc_control u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .opcode(opcode),
    .funct (funct),
    .ctl   (ctl)
  );

  sc_datapath #(.IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(DMEM_WORDS)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .opcode    (opcode),
    .funct     (funct),
    .dbgPc     (dbgPc),
    .dbgRegWe  (dbgRegWe),
    .dbgRegAddr(dbgRegAddr),
    .dbgRegData(dbgRegData)
  );

  // R1: reset returns the PC to zero
  a_r1_reset_pc: assert property (@(posedge clk) rst |=> dbgPc == 32'd0);

endmodule

// File: tb/tb_sc_cpu_core.sv
module tb_sc_cpu_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dbgPc;
  logic        dbgRegWe;
  logic [4:0]  dbgRegAddr;
  logic [31:0] dbgRegData;

  int checks = 0;
  int bad = 0;
  logic running = 1'b0;

  always #2.5 clk = ~clk;

  sc_cpu_core dut (
    .clk(clk), .rst(rst), .dbgPc(dbgPc), .dbgRegWe(dbgRegWe),
    .dbgRegAddr(dbgRegAddr), .dbgRegData(dbgRegData)
  );

  typedef struct {
    logic [31:0] pc;
    logic        we;
    logic [4:0]  addr;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t expQ[$];

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic push(logic [31:0] pc, logic we, int addr, logic [31:0] data, string tag);
    exp_t e;
    e.pc = pc; e.we = we; e.addr = 5'(addr); e.data = data; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: pops one expected item per executed instruction
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (running && expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        check({e.tag, " pc"}, dbgPc, e.pc);
        check({e.tag, " we"}, {31'd0, dbgRegWe}, {31'd0, e.we});
        if (e.we) begin
          check({e.tag, " addr"}, {27'd0, dbgRegAddr}, {27'd0, e.addr});
          check({e.tag, " data"}, dbgRegData, e.data);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  // driver
  initial begin
    #1;
    dut.u_dp.dmem[0] <= 32'd5;
    dut.u_dp.dmem[1] <= 32'd7;
    dut.u_dp.dmem[2] <= 32'hFFFF_FFFD;
    dut.u_dp.dmem[3] <= 32'h0000_0100;
    dut.u_dp.imem[0]  = enc_i(6'h23, 0, 1, 16'd0);
    dut.u_dp.imem[1]  = enc_i(6'h23, 0, 2, 16'd4);
    dut.u_dp.imem[2]  = enc_i(6'h23, 0, 3, 16'd8);
    dut.u_dp.imem[3]  = enc_r(1, 2, 4, 6'h20);
    dut.u_dp.imem[4]  = enc_r(1, 2, 5, 6'h22);
    dut.u_dp.imem[5]  = enc_r(1, 2, 6, 6'h24);
    dut.u_dp.imem[6]  = enc_r(1, 2, 7, 6'h25);
    dut.u_dp.imem[7]  = enc_r(3, 1, 8, 6'h2A);
    dut.u_dp.imem[8]  = enc_r(1, 3, 9, 6'h2A);
    dut.u_dp.imem[9]  = enc_r(1, 2, 0, 6'h20);
    dut.u_dp.imem[10] = enc_r(0, 0, 10, 6'h20);
    dut.u_dp.imem[11] = enc_i(6'h2B, 0, 4, 16'd16);
    dut.u_dp.imem[12] = enc_i(6'h23, 0, 11, 16'd16);
    dut.u_dp.imem[13] = enc_i(6'h04, 1, 2, 16'd5);
    dut.u_dp.imem[14] = enc_i(6'h04, 1, 1, 16'd2);
    dut.u_dp.imem[15] = enc_r(1, 1, 12, 6'h20);
    dut.u_dp.imem[16] = enc_r(1, 1, 12, 6'h20);
    dut.u_dp.imem[17] = {6'h02, 26'h200_0014};
    dut.u_dp.imem[18] = enc_r(1, 1, 13, 6'h20);
    dut.u_dp.imem[19] = enc_r(1, 1, 13, 6'h20);
    dut.u_dp.imem[20] = enc_r(4, 1, 13, 6'h20);
    dut.u_dp.imem[21] = enc_i(6'h04, 0, 0, 16'hFFFF);

    push(32'd0,  1, 1,  32'd5,        "R3 lw r1");
    push(32'd4,  1, 2,  32'd7,        "R3 lw r2");
    push(32'd8,  1, 3,  32'hFFFFFFFD, "R3 lw r3 negative");
    push(32'd12, 1, 4,  32'd12,       "R5 add");
    push(32'd16, 1, 5,  32'hFFFFFFFE, "R5 sub");
    push(32'd20, 1, 6,  32'd5,        "R5 and");
    push(32'd24, 1, 7,  32'd7,        "R5 or");
    push(32'd28, 1, 8,  32'd1,        "R6 slt signed true");
    push(32'd32, 1, 9,  32'd0,        "R6 slt signed false");
    push(32'd36, 0, 0,  32'd0,        "R7 write to r0 dropped");
    push(32'd40, 1, 10, 32'd0,        "R7 r0 reads zero");
    push(32'd44, 0, 0,  32'd0,        "R4 sw no reg write");
    push(32'd48, 1, 11, 32'd12,       "R4 load after store");
    push(32'd52, 0, 0,  32'd0,        "R8 beq not taken");
    push(32'd56, 0, 0,  32'd0,        "R8 beq taken");
    push(32'd68, 0, 0,  32'd0,        "R8 R10 target and jump");
    push(32'h08000050, 1, 13, 32'd17, "R9 jump target");
    push(32'h08000054, 0, 0, 32'd0,   "R2 after jump");
    push(32'h08000054, 0, 0, 32'd0,   "R8 backward branch");
    push(32'h08000054, 0, 0, 32'd0,   "R8 backward branch hold");

    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    check("R1 reset pc", dbgPc, 32'd0);
    check("R1 reset no write", {31'd0, dbgRegWe}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    running = 1'b1;
    wait (expQ.size() == 0);
    @(posedge clk);

    // mid-run reset and restart
    @(negedge clk);
    running = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    #1;
    check("R1 mid-run reset pc", dbgPc, 32'd0);
    check("R1 mid-run reset no write", {31'd0, dbgRegWe}, 32'd0);
    push(32'd0, 1, 1, 32'd5, "R1 R2 restart lw r1");
    push(32'd4, 1, 2, 32'd7, "R1 R2 restart lw r2");
    @(negedge clk);
    rst = 1'b0;
    running = 1'b1;
    wait (expQ.size() == 0);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule